// File: doc/BRIEF.md
# Serial Interrupt Peripheral Agent

This block is the device end of a single-wire, open-drain serial interrupt bus that runs on a shared clock. It watches every low pulse on the line. A low pulse of at least four clocks opens a cycle. The agent then counts clocks through the data frames. In the sample phase of its own frame it pulls the line low when its local interrupt is asserted, and leaves the line alone when it is not. Each frame is three clocks long, and the agent drives in no phase other than its own sample phase.

The host ends each cycle with a short low pulse. Its length sets the bus mode for the next period: two clocks selects quiet mode and three clocks selects continuous mode. In quiet mode the agent may open a cycle itself when its interrupt level has changed since it was last reported. To do so it pulls the line low for one clock and lets the host stretch the pulse. In continuous mode only the host opens cycles. After reset the agent assumes continuous mode and does not drive until it has seen one complete end-of-cycle pulse.

Top module: `sirq_agent`

## Requirements
- R1: While rst_ni is low and after reset, line_oe_o is 0. The agent does not drive in any frame until it has seen one end-of-cycle pulse.
- R2: If a low pulse of at least 4 clocks ends with line_i first high in cycle c, then for slot number n (1 to 32) the agent drives line_oe_o=1 in cycle c+3n-1 when irq_ni is low.
- R3: When irq_ni is high during the sample phase of its slot, the agent does not drive.
- R4: Every drive lasts exactly one clock. The agent never drives in the recovery or turnaround clocks of any frame.
- R5: A low pulse shorter than 4 clocks seen while no cycle is in progress does not open a cycle, and no slot drive follows it.
- R6: Within a cycle, a low pulse of 2 clocks ends the cycle and selects quiet mode. A low pulse of 3 clocks ends the cycle and selects continuous mode.
- R7: In quiet mode, when irq_ni differs from the level last reported in the slot, the agent drives for one clock. The earliest drive is 2 clocks after the first high cycle that follows the end-of-cycle pulse, and otherwise it comes one clock after the change.
- R8: In continuous mode the agent never opens a cycle, whatever irq_ni does.
- R9: Slot number 0 disables slot drives.
- R10: After opening a cycle, the agent makes no further request until a cycle start has been seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| slot_i | input | 6 | Assigned frame number; 0 disables slot drives |
| irq_ni | input | 1 | Local interrupt, active low |
| line_i | input | 1 | Sensed level of the serial line |
| line_oe_o | output | 1 | 1 pulls the line low; 0 releases it |

## Verification
A slot drive is due 3n-1 cycles after the first high cycle that follows a start pulse. A quiet-mode request is due one cycle after irq_ni changes, and never earlier than two cycles after the end-of-cycle rise. The host model returns the cycle number of each rising edge, and the driver tasks push the exact due cycle into a queue. The monitor samples line_oe_o on every falling edge. It fails any drive that has no queued entry for that cycle, and any queued entry whose cycle passes with no drive. Windows where the agent must stay silent are checked the same way, with the queue left empty.

// File: rtl/sirq_agent_pkg.sv
package sirq_agent_pkg;
  typedef enum logic {ST_IDLE, ST_FRAME} trk_state_e;
  typedef enum logic {MODE_CONT, MODE_QUIET} bus_mode_e;
endpackage

// File: rtl/sirq_low_meter.sv
module sirq_low_meter #(
  parameter int LEN_MAX = 4,
  localparam int LEN_W  = $clog2(LEN_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             line_i,
  output logic             rise_o,
  output logic [LEN_W-1:0] len_o
);
  logic [LEN_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (line_i)             cnt_q <= '0;
    else if (cnt_q != LEN_W'(LEN_MAX)) cnt_q <= cnt_q + 1'b1;
  end

  assign rise_o = line_i && (cnt_q != '0);
  assign len_o  = cnt_q;

  // R5
  low_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_i |=> (len_o != '0));
endmodule

// File: rtl/sirq_frame_tracker.sv
module sirq_frame_tracker
  import sirq_agent_pkg::*;
#(
  parameter int MAX_FRAMES = 32,
  parameter int START_MIN  = 4,
  parameter int STOP_QUIET = 2,
  parameter int STOP_CONT  = 3,
  parameter int HOLD_OFF   = 2,
  localparam int LEN_W     = $clog2(START_MIN + 1),
  localparam int POS_MAX   = 3 * MAX_FRAMES,
  localparam int POS_W     = $clog2(POS_MAX + 1),
  localparam int HOLD_W    = $clog2(HOLD_OFF + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  input  logic [LEN_W-1:0] len_i,
  output trk_state_e       state_o,
  output bus_mode_e        mode_o,
  output logic             armed_o,
  output logic [POS_W-1:0] pos_o,
  output logic             start_o,
  output logic             hold_ok_o
);
  trk_state_e        state_q;
  bus_mode_e         mode_q;
  logic              armed_q;
  logic [POS_W-1:0]  pos_q;
  logic [HOLD_W-1:0] idle_q;
  logic              stop_det;

  assign start_o  = rise_i && (len_i >= LEN_W'(START_MIN));
  assign stop_det = (state_q == ST_FRAME) && rise_i &&
                    ((len_i == LEN_W'(STOP_QUIET)) || (len_i == LEN_W'(STOP_CONT)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mode_q  <= MODE_CONT;
      armed_q <= 1'b0;
      pos_q   <= '0;
      idle_q  <= '0;
    end else if (start_o) begin
      state_q <= ST_FRAME;
      pos_q   <= POS_W'(1);
      idle_q  <= '0;
    end else if (stop_det) begin
      state_q <= ST_IDLE;
      mode_q  <= (len_i == LEN_W'(STOP_QUIET)) ? MODE_QUIET : MODE_CONT;
      armed_q <= 1'b1;
      idle_q  <= HOLD_W'(1);
    end else if (state_q == ST_FRAME) begin
      if (pos_q != POS_W'(POS_MAX)) pos_q <= pos_q + 1'b1;
    end else if (idle_q != HOLD_W'(HOLD_OFF)) begin
      idle_q <= idle_q + 1'b1;
    end
  end

  assign state_o   = state_q;
  assign mode_o    = mode_q;
  assign armed_o   = armed_q;
  assign pos_o     = pos_q;
  // drive registered now lands on the HOLD_OFF-th clock after the rise
  assign hold_ok_o = (state_q == ST_IDLE) && (mode_q == MODE_QUIET) && armed_q &&
                     (idle_q >= HOLD_W'(HOLD_OFF - 1));

  // R6
  stop_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_det && (len_i == LEN_W'(STOP_QUIET))) |=> (mode_q == MODE_QUIET) && (state_q == ST_IDLE));
  // R6
  stop_cont_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_det && (len_i == LEN_W'(STOP_CONT))) |=> (mode_q == MODE_CONT) && (state_q == ST_IDLE));
  // R2
  pos_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_FRAME) && !rise_i && (pos_q != POS_W'(POS_MAX))) |=> (pos_q == $past(pos_q) + 1'b1));
endmodule

// File: rtl/sirq_drive_ctl.sv
module sirq_drive_ctl
  import sirq_agent_pkg::*;
#(
  parameter int SLOT_W = 6,
  parameter int POS_W  = 7,
  localparam int TW    = ((SLOT_W + 2) > (POS_W + 1)) ? (SLOT_W + 2) : (POS_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic              irq_ni,
  input  logic              line_i,
  input  trk_state_e        state_i,
  input  bus_mode_e         mode_i,
  input  logic              armed_i,
  input  logic [POS_W-1:0]  pos_i,
  input  logic              start_i,
  input  logic              hold_ok_i,
  output logic              oe_o
);
  logic          oe_q, last_rep_q, req_pend_q;
  logic [TW-1:0] target, pos_nx;
  logic          slot_hit, req_fire;

  assign target   = TW'(slot_i) + TW'(slot_i) + TW'(slot_i) - TW'(1);
  assign pos_nx   = TW'(pos_i) + TW'(1);
  assign slot_hit = (state_i == ST_FRAME) && armed_i && (slot_i != '0) && (pos_nx == target);
  assign req_fire = hold_ok_i && line_i && !req_pend_q && !oe_q && (irq_ni != last_rep_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_q       <= 1'b0;
      last_rep_q <= 1'b1;
      req_pend_q <= 1'b0;
    end else begin
      oe_q <= (slot_hit && !irq_ni) || req_fire;
      if (slot_hit) last_rep_q <= irq_ni;
      if (start_i)       req_pend_q <= 1'b0;
      else if (req_fire) req_pend_q <= 1'b1;
    end
  end

  assign oe_o = oe_q;

  // R4
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_q |=> !oe_q);
  // R1
  unarmed_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_i |-> !oe_q);
  // R8
  cont_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_i == MODE_CONT) && (state_i == ST_IDLE) && ($past(state_i) == ST_IDLE)) |-> !oe_q);
  // R10
  one_request_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_pend_q && $past(req_pend_q) && (state_i == ST_IDLE)) |-> !oe_q);
endmodule

// File: rtl/sirq_agent.sv
module sirq_agent
  import sirq_agent_pkg::*;
#(
  parameter int MAX_FRAMES = 32,
  parameter int START_MIN  = 4,
  parameter int STOP_QUIET = 2,
  parameter int STOP_CONT  = 3,
  parameter int HOLD_OFF   = 2,
  localparam int SLOT_W    = $clog2(MAX_FRAMES + 1),
  localparam int LEN_W     = $clog2(START_MIN + 1),
  localparam int POS_W     = $clog2(3 * MAX_FRAMES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic              irq_ni,
  input  logic              line_i,
  output logic              line_oe_o
);
  logic             rise;
  logic [LEN_W-1:0] len;
  trk_state_e       state;
  bus_mode_e        mode;
  logic             armed, start, hold_ok;
  logic [POS_W-1:0] pos;

  sirq_low_meter #(.LEN_MAX(START_MIN)) u_meter (
    .clk_i, .rst_ni, .line_i, .rise_o(rise), .len_o(len)
  );

  sirq_frame_tracker #(
    .MAX_FRAMES(MAX_FRAMES), .START_MIN(START_MIN), .STOP_QUIET(STOP_QUIET),
    .STOP_CONT(STOP_CONT), .HOLD_OFF(HOLD_OFF)
  ) u_track (
    .clk_i, .rst_ni, .rise_i(rise), .len_i(len), .state_o(state), .mode_o(mode),
    .armed_o(armed), .pos_o(pos), .start_o(start), .hold_ok_o(hold_ok)
  );

  sirq_drive_ctl #(.SLOT_W(SLOT_W), .POS_W(POS_W)) u_drive (
    .clk_i, .rst_ni, .slot_i, .irq_ni, .line_i, .state_i(state), .mode_i(mode),
    .armed_i(armed), .pos_i(pos), .start_i(start), .hold_ok_i(hold_ok), .oe_o(line_oe_o)
  );
endmodule

// File: tb/sirq_agent_tb.sv
module sirq_agent_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] slot = 6'd3;
  logic       irq_n = 1'b1;
  logic       host_low = 1'b0;
  logic       oe;
  logic       line;
  int         cyc = 0;
  int         vectors = 0;
  int         errors = 0;
  int         unexp = 0;
  string      cur_tag = "R1";

  typedef struct { int at; string tag; } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign line = !(oe || host_low);

  sirq_agent dut_i (
    .clk_i(clk), .rst_ni(rst_n), .slot_i(slot), .irq_ni(irq_n),
    .line_i(line), .line_oe_o(oe)
  );

  task automatic push(input int at, input string tag);
    exp_t e;
    e.at = at; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // host holds line low n clocks; r = first high cycle after
  task automatic pulse(input int n, output int r);
    repeat (n) begin @(negedge clk); host_low = 1'b1; end
    @(negedge clk); host_low = 1'b0;
    r = cyc;
  endtask

  task automatic expect_quiet(input int n, input string tag);
    int u0;
    u0 = unexp;
    idle(n);
    vectors++;
    if (unexp != u0) begin
      errors++;
      $display("FAIL %s: silent window saw %0d drives, expected 0", tag, unexp - u0);
    end
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        while (q.size() > 0 && q[0].at < cyc) begin
          vectors++; errors++;
          $display("FAIL %s: no drive at cycle %0d, expected oe=1 got 0", q[0].tag, q[0].at);
          void'(q.pop_front());
        end
        if (oe) begin
          if (q.size() > 0 && q[0].at == cyc) begin
            vectors++;
            void'(q.pop_front());
          end else begin
            vectors++; errors++; unexp++;
            $display("FAIL %s: drive at cycle %0d, expected oe=0 got 1", cur_tag, cyc);
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    int r, d;
    idle(3);
    vectors++;
    if (oe !== 1'b0) begin errors++; $display("FAIL R1: oe in reset got %b expected 0", oe); end
    rst_n = 1'b1;
    idle(5);
    vectors++;
    if (oe !== 1'b0) begin errors++; $display("FAIL R1: oe after reset got %b expected 0", oe); end

    // R1: first cycle before any stop stays silent
    cur_tag = "R1"; irq_n = 1'b0;
    pulse(4, r); idle(20); pulse(3, r); idle(5);

    // R2: slot 3, continuous
    cur_tag = "R4";
    pulse(4, r); push(r + 8, "R2"); idle(20); pulse(3, r); idle(5);

    // R3: interrupt inactive
    cur_tag = "R3"; irq_n = 1'b1;
    pulse(4, r); idle(20); pulse(3, r);
    expect_quiet(5, "R3");

    // R8: continuous mode, level change does not start a cycle
    cur_tag = "R8"; irq_n = 1'b0;
    expect_quiet(40, "R8");

    // R5: short pulse from idle is no start
    cur_tag = "R5";
    pulse(3, r);
    expect_quiet(30, "R5");

    // R2 boundaries: slot 1 and slot 32
    cur_tag = "R4"; slot = 6'd1;
    pulse(4, r); push(r + 2, "R2"); idle(10); pulse(3, r); idle(5);
    slot = 6'd32;
    pulse(4, r); push(r + 95, "R2"); idle(100); pulse(3, r); idle(5);

    // R9: slot 0 silent; then R6/R7 quiet request at earliest point
    cur_tag = "R9"; slot = 6'd0;
    pulse(4, r); idle(30);
    irq_n = 1'b1;
    pulse(2, r); push(r + 2, "R7");
    cur_tag = "R10";
    expect_quiet(20, "R10");

    // host opens cycle; slot 2 reports high
    cur_tag = "R3"; slot = 6'd2;
    pulse(4, r); idle(15); pulse(2, r);
    idle(5);
    cur_tag = "R7"; irq_n = 1'b0; d = cyc;
    push(d + 1, "R7");
    idle(1);
    // host stretches the request pulse to 4 clocks
    pulse(3, r);
    vectors++;
    if (r != d + 5) begin errors++; $display("FAIL R7: rise at %0d expected %0d", r, d + 5); end
    cur_tag = "R4";
    push(r + 5, "R2");
    idle(15); pulse(3, r);

    // R6: 3-clock stop returns to continuous
    cur_tag = "R8"; irq_n = 1'b1;
    expect_quiet(20, "R6");
    irq_n = 1'b0;
    expect_quiet(20, "R8");

    while (q.size() > 0) begin
      vectors++; errors++;
      $display("FAIL %s: missing drive at %0d, expected oe=1 got 0", q[0].tag, q[0].at);
      void'(q.pop_front());
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule